// File: doc/BRIEF.md
# Two-channel interleaved MASH 1-1 delta-sigma modulator

This block is a digital second-order delta-sigma modulator that runs at half the output sample rate. Each clock it takes a pair of consecutive two's-complement input samples. The even sample is the earlier one in time and the odd sample is the later one. For each pair it returns two coarse output codes. A later full-rate multiplexer, which is not part of this block, interleaves them. The noise-shaping loop is a cascade of two first-order error-feedback accumulators, so the noise transfer function is (1 - z^-1)^2. That loop is unrolled across the two lanes: within one cycle the odd lane starts from the state the even lane has just produced. Each code is also decoded into a thermometer vector that drives unit cells of equal weight. A plain control pin selects an optional two-tap FIR after the modulator. This filter adds each code to the one before it, which gives one more bit of output and twice as many cells, and makes the interleaved output tolerant of timing skew between the two lanes.

Input and output are valid/ready streams, and each transfer carries one sample pair. A pair enters on a rising edge where `in_valid` and `in_ready` are both high. An output pair is consumed on a rising edge where `out_valid` and `out_ready` are both high. The pipeline moves as one unit. `in_ready` is low exactly when the output register holds a pair that the downstream side is refusing. During such a stall every stage holds its contents and no state advances. The source may drop `in_valid` at any time, and the resulting bubble leaves the modulator state untouched. The input side must keep `fir_en` steady while pairs are in flight if it wants a clean switch between modes.

Top module: `ilv_mash_mod`

## Requirements
- R1: A pair is taken on an edge with in_valid and in_ready both high, and `in_ready` equals (not out_valid) or out_ready. While out_valid is high and out_ready is low, out_valid and all four output buses stay unchanged. Every accepted pair leaves exactly once, in order.
- R2: A synchronous active-high `rst` clears both accumulators, the previous-carry bit and the previous-code history to zero, and clears every valid flag. In the cycle after reset `out_valid` is low and `in_ready` is high.
- R3: First stage: u = x + 2^(IW-1) is an unsigned IW-bit value. The stage adds u to its (IW-2)-bit residue. Its carry c1 = sum >> (IW-2) lies in 0..4, and the low IW-2 bits of the sum become the new residue.
- R4: Second stage: it adds the first-stage residue to its own (IW-2)-bit residue. Its carry c2 is bit IW-2 of that sum, and the low bits become its new residue. The modulator code is m = c1 + c2[n] - c2[n-1] + 1, which lies in 0..6.
- R5: Sample order is even lane first, then odd lane. The odd lane continues from the even lane's updated residues and uses the even lane's c2 as its previous carry. The even lane uses the odd lane's state and c2 from the previous accepted pair.
- R6: With `fir_en` high the output code is f = m[n] + m[n-1], which lies in 0..12. For the even lane, m[n-1] is the odd code of the previous accepted pair. The history keeps updating while `fir_en` is low, and it reads 0 right after reset. `fir_en` is sampled when a pair moves into the output register. With `fir_en` low the output code is m.
- R7: Each thermometer output has 14 bits. Bit i is 1 exactly when the output code is greater than i, so without the FIR bits 7..13 are always 0.
- R8: With no stall, a pair taken on a rising edge appears on the outputs after the second rising edge that follows it.
- R9: A cycle that accepts no pair leaves both residues and both histories unchanged, so gaps in the input stream do not alter the output sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| fir_en | input | 1 | Selects the two-tap FIR output |
| in_valid | input | 1 | Input pair present |
| in_ready | output | 1 | Block can take a pair this edge |
| in_even | input | IW (12) | Earlier sample of the pair, two's complement |
| in_odd | input | IW (12) | Later sample of the pair, two's complement |
| out_valid | output | 1 | Output pair present |
| out_ready | input | 1 | Downstream takes the pair this edge |
| out_code_even | output | 4 | Code of the even lane |
| out_code_odd | output | 4 | Code of the odd lane |
| out_therm_even | output | 14 | Unit-cell drive of the even lane |
| out_therm_odd | output | 14 | Unit-cell drive of the odd lane |

## Verification
Within one cycle, a stall on the output side can meet a new input pair, and it can also meet a bubble in the unrolled loop. The bench brings these about together by drawing out_ready and in_valid at random on every clock. It keeps each refused pair on the input until that pair is taken. It then compares every delivered pair with a full-rate model that has no notion of lanes or stalls, and checks that a held output does not move. The FIR history across a switch of `fir_en` is covered in the same way: the bench drains the pipeline, turns the filter on, and expects the first filtered even code to fold in the last code produced before the switch.

// File: rtl/ilv_mash_pkg.sv
package ilv_mash_pkg;

  // two polyphase lanes share one half-rate clock
  localparam int LANES = 2;

  // distinct modulator code values for a QB-bit first quantizer:
  // c1 in 0..2^QB, difference term in -1..1, offset by one
  function automatic int mod_levels(input int qb);
    return (1 << qb) + 3;
  endfunction

endpackage

// File: rtl/ilv_mash_loop.sv
module ilv_mash_loop
  import ilv_mash_pkg::*;
#(
  parameter int IW = 12,
  parameter int QB = 2
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     en,
  input  logic                     in_vld,
  input  logic [LANES-1:0][IW-1:0] x_in,
  output logic                     vld_q,
  output logic [LANES-1:0][QB:0]   c1_q,
  output logic [LANES-1:0]         c2_q
);

  localparam int L = IW - QB;

  logic [L-1:0] e1_q, e2_q;
  logic [L-1:0] r1 [LANES+1];
  logic [L-1:0] r2 [LANES+1];
  logic [LANES-1:0][QB:0] c1_w;
  logic [LANES-1:0]       c2_w;

  assign r1[0] = e1_q;
  assign r2[0] = e2_q;

  // unrolled loop: lane k+1 starts from the residues lane k leaves
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [IW-1:0] u;
    logic [IW:0]   s1;
    logic [L:0]    s2;

    assign u  = {~x_in[k][IW-1], x_in[k][IW-2:0]};
    assign s1 = {1'b0, u} + {{(QB+1){1'b0}}, r1[k]};
    assign c1_w[k]  = s1[IW:L];
    assign r1[k+1]  = s1[L-1:0];
    assign s2 = {1'b0, r2[k]} + {1'b0, r1[k+1]};
    assign c2_w[k]  = s2[L];
    assign r2[k+1]  = s2[L-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      e1_q  <= '0;
      e2_q  <= '0;
      c1_q  <= '0;
      c2_q  <= '0;
    end else if (en) begin
      vld_q <= in_vld;
      if (in_vld) begin
        e1_q <= r1[LANES];
        e2_q <= r2[LANES];
        c1_q <= c1_w;
        c2_q <= c2_w;
      end
    end
  end

  // first-stage carry never exceeds 2^QB
  assert_c1_range_R3: assert property (@(posedge clk) disable iff (rst)
    vld_q |-> (c1_q[0] <= (QB+1)'(1 << QB)) && (c1_q[LANES-1] <= (QB+1)'(1 << QB)));

  // a cycle with no accepted pair leaves the loop state alone
  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !(en && in_vld) |=> $stable(e1_q) && $stable(e2_q));

endmodule

// File: rtl/ilv_mash_shape.sv
module ilv_mash_shape
  import ilv_mash_pkg::*;
#(
  parameter  int QB = 2,
  localparam int MW = $clog2(mod_levels(QB)),
  localparam int FW = MW + 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   en,
  input  logic                   in_vld,
  input  logic [LANES-1:0][QB:0] c1,
  input  logic [LANES-1:0]       c2,
  output logic                   vld_q,
  output logic [LANES-1:0][MW-1:0] mod_q,
  output logic [LANES-1:0][FW-1:0] fir_q
);

  logic          c2_last;
  logic [MW-1:0] code_last;
  logic          c2p [LANES+1];
  logic [MW-1:0] cp  [LANES+1];
  logic [LANES-1:0][MW-1:0] code_w;
  logic [LANES-1:0][FW-1:0] fir_w;

  assign c2p[0] = c2_last;
  assign cp[0]  = code_last;

  // difference the second carry and sum neighbouring codes in sample order
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign code_w[k] = MW'(c1[k]) + MW'(c2[k]) + MW'(1) - MW'(c2p[k]);
    assign fir_w[k]  = FW'(code_w[k]) + FW'(cp[k]);
    assign cp[k+1]   = code_w[k];
    assign c2p[k+1]  = c2[k];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q     <= 1'b0;
      mod_q     <= '0;
      fir_q     <= '0;
      c2_last   <= 1'b0;
      code_last <= '0;
    end else if (en) begin
      vld_q <= in_vld;
      if (in_vld) begin
        mod_q     <= code_w;
        fir_q     <= fir_w;
        c2_last   <= c2p[LANES];
        code_last <= cp[LANES];
      end
    end
  end

  // modulator code range 0 .. 2^QB+2
  assert_code_range_R4: assert property (@(posedge clk) disable iff (rst)
    vld_q |-> (mod_q[0] <= MW'((1 << QB) + 2)) && (mod_q[LANES-1] <= MW'((1 << QB) + 2)));

  // the even filtered code folds in the odd code of the previous pair
  assert_fir_link_R6: assert property (@(posedge clk) disable iff (rst)
    (en && in_vld) |=> fir_q[0] == FW'(mod_q[0]) + FW'($past(mod_q[LANES-1])));

endmodule

// File: rtl/ilv_mash_therm.sv
module ilv_mash_therm #(
  parameter int CW    = 4,
  parameter int CELLS = 14
) (
  input  logic [CW-1:0]    code,
  output logic [CELLS-1:0] cells
);

  for (genvar i = 0; i < CELLS; i++) begin : g_cell
    assign cells[i] = (code > CW'(i));
  end

endmodule

// File: rtl/ilv_mash_mod.sv
module ilv_mash_mod
  import ilv_mash_pkg::*;
#(
  parameter  int IW    = 12,
  parameter  int QB    = 2,
  localparam int MW    = $clog2(mod_levels(QB)),
  localparam int FW    = MW + 1,
  localparam int CELLS = 2 * ((1 << MW) - 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fir_en,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IW-1:0]    in_even,
  input  logic [IW-1:0]    in_odd,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [FW-1:0]    out_code_even,
  output logic [FW-1:0]    out_code_odd,
  output logic [CELLS-1:0] out_therm_even,
  output logic [CELLS-1:0] out_therm_odd
);

  logic adv;
  logic v1, v2, v3_q;
  logic [LANES-1:0][IW-1:0] x_in;
  logic [LANES-1:0][QB:0]   c1;
  logic [LANES-1:0]         c2;
  logic [LANES-1:0][MW-1:0] mod_code;
  logic [LANES-1:0][FW-1:0] fir_code;
  logic [LANES-1:0][FW-1:0] sel_code;
  logic [LANES-1:0][CELLS-1:0] therm_w;
  logic [LANES-1:0][FW-1:0]    code3_q;
  logic [LANES-1:0][CELLS-1:0] therm3_q;

  // whole pipeline moves together unless a held output is refused
  assign adv      = !v3_q || out_ready;
  assign in_ready = adv;
  assign x_in     = {in_odd, in_even};

  ilv_mash_loop #(.IW(IW), .QB(QB)) loop_i (
    .clk   (clk),
    .rst   (rst),
    .en    (adv),
    .in_vld(in_valid),
    .x_in  (x_in),
    .vld_q (v1),
    .c1_q  (c1),
    .c2_q  (c2)
  );

  ilv_mash_shape #(.QB(QB)) shape_i (
    .clk   (clk),
    .rst   (rst),
    .en    (adv),
    .in_vld(v1),
    .c1    (c1),
    .c2    (c2),
    .vld_q (v2),
    .mod_q (mod_code),
    .fir_q (fir_code)
  );

  for (genvar k = 0; k < LANES; k++) begin : g_out
    assign sel_code[k] = fir_en ? fir_code[k] : FW'(mod_code[k]);
    ilv_mash_therm #(.CW(FW), .CELLS(CELLS)) therm_i (
      .code (sel_code[k]),
      .cells(therm_w[k])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v3_q     <= 1'b0;
      code3_q  <= '0;
      therm3_q <= '0;
    end else if (adv) begin
      v3_q <= v2;
      if (v2) begin
        code3_q  <= sel_code;
        therm3_q <= therm_w;
      end
    end
  end

  assign out_valid      = v3_q;
  assign out_code_even  = code3_q[0];
  assign out_code_odd   = code3_q[LANES-1];
  assign out_therm_even = therm3_q[0];
  assign out_therm_odd  = therm3_q[LANES-1];

  assert_hold_R1: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> out_valid && $stable(out_code_even) && $stable(out_code_odd)
      && $stable(out_therm_even) && $stable(out_therm_odd));

  assert_reset_clear_R2: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid);

  assert_therm_count_R7: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ($countones(out_therm_even) == int'(out_code_even))
      && ($countones(out_therm_odd) == int'(out_code_odd)));

endmodule

// File: tb/ilv_mash_mod_tb_top.sv
`timescale 1ns/1ps
module ilv_mash_mod_tb_top;

  localparam int IW    = 12;
  localparam int QB    = 2;
  localparam int FW    = 4;
  localparam int CELLS = 14;
  localparam int SCALE = 1 << (IW - QB);
  localparam int HALF  = 1 << (IW - 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fir_en = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic [IW-1:0] in_even = '0;
  logic [IW-1:0] in_odd  = '0;
  logic out_valid;
  logic out_ready = 1'b0;
  logic [FW-1:0] out_code_even, out_code_odd;
  logic [CELLS-1:0] out_therm_even, out_therm_odd;

  always #2.5 clk = ~clk;

  ilv_mash_mod dut_i (
    .clk(clk), .rst(rst), .fir_en(fir_en),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_even(in_even), .in_odd(in_odd),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_code_even(out_code_even), .out_code_odd(out_code_odd),
    .out_therm_even(out_therm_even), .out_therm_odd(out_therm_odd)
  );

  int n_chk = 0;
  int n_bad = 0;
  int m_e1 = 0, m_e2 = 0, m_c2p = 0, m_codep = 0;
  int q_mod[$];
  int q_fir[$];
  string cur_tag = "R4";
  bit hold_pend = 0;
  int held_e, held_o;
  bit last_acc = 0;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // full-rate reference: one sample at a time, no lanes
  task automatic model_sample(input int x);
    int s1, c1, s2, c2, code;
    s1 = m_e1 + x + HALF;
    c1 = s1 / SCALE;
    m_e1 = s1 % SCALE;
    s2 = m_e2 + m_e1;
    c2 = s2 / SCALE;
    m_e2 = s2 % SCALE;
    code = c1 + c2 - m_c2p + 1;
    m_c2p = c2;
    q_mod.push_back(code);
    q_fir.push_back(code + m_codep);
    m_codep = code;
  endtask

  task automatic compare_out();
    int em, ef, om, of_, ee, eo;
    if (q_mod.size() < 2) begin
      chk("R1 unexpected output", 1, 0);
      return;
    end
    em = q_mod.pop_front(); ef = q_fir.pop_front();
    om = q_mod.pop_front(); of_ = q_fir.pop_front();
    ee = fir_en ? ef : em;
    eo = fir_en ? of_ : om;
    chk(cur_tag, int'(out_code_even), ee);
    chk("R5 odd lane", int'(out_code_odd), eo);
    chk("R7 even cells", int'(out_therm_even), (1 << ee) - 1);
    chk("R7 odd cells", int'(out_therm_odd), (1 << eo) - 1);
  endtask

  task automatic step(input bit iv, input int xe, input int xo, input bit ordy);
    @(negedge clk);
    in_valid  = iv;
    in_even   = IW'(xe);
    in_odd    = IW'(xo);
    out_ready = ordy;
    #1;
    if (hold_pend) begin
      chk("R1 held valid", int'(out_valid), 1);
      chk("R1 held even", int'(out_code_even), held_e);
      chk("R1 held odd", int'(out_code_odd), held_o);
      hold_pend = 0;
    end
    if (out_valid && !out_ready) begin
      hold_pend = 1;
      held_e = int'(out_code_even);
      held_o = int'(out_code_odd);
    end
    if (out_valid && out_ready) compare_out();
    last_acc = in_valid && in_ready;
    if (last_acc) begin
      model_sample(xe);
      model_sample(xo);
    end
  endtask

  task automatic drain();
    for (int i = 0; i < 40 && q_mod.size() > 0; i++) step(0, 0, 0, 1);
    chk("R1 all delivered", q_mod.size(), 0);
  endtask

  task automatic stream_rand(input int pairs, input bit gaps);
    int xe, xo, got;
    xe = int'($urandom_range(0, 4095)) - HALF;
    xo = int'($urandom_range(0, 4095)) - HALF;
    got = 0;
    while (got < pairs) begin
      step(gaps ? ($urandom_range(0, 3) != 0) : 1'b1, xe, xo,
           gaps ? ($urandom_range(0, 2) != 0) : 1'b1);
      if (last_acc) begin
        got++;
        xe = int'($urandom_range(0, 4095)) - HALF;
        xo = int'($urandom_range(0, 4095)) - HALF;
      end
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    q_mod.delete(); q_fir.delete();
    m_e1 = 0; m_e2 = 0; m_c2p = 0; m_codep = 0;
    hold_pend = 0;
    #1;
    chk("R2 out_valid after reset", int'(out_valid), 0);
    chk("R2 in_ready after reset", int'(in_ready), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    do_reset();

    // R8: pair accepted on edge 1 appears after edge 3
    cur_tag = "R8";
    step(1, 300, -300, 1);
    step(0, 0, 0, 1);
    step(0, 0, 0, 1);
    chk("R8 not yet valid", int'(out_valid), 0);
    step(0, 0, 0, 1);
    chk("R8 valid", int'(out_valid), 1);
    drain();

    // R4: mid-scale input
    cur_tag = "R4";
    for (int i = 0; i < 40; i++) step(1, 0, 0, 1);
    drain();

    // R3: ramp across the full range, no stalls
    cur_tag = "R3";
    for (int i = 0; i < 60; i++) step(1, -2048 + i * 68, -2014 + i * 68, 1);
    drain();

    // R9: random values with bubbles and back-pressure
    cur_tag = "R9";
    stream_rand(300, 1'b1);
    drain();

    // R6: filter on, history carried over from the unfiltered run
    fir_en = 1'b1;
    cur_tag = "R6";
    for (int i = 0; i < 30; i++) step(1, 2047, -2048, 1);
    for (int i = 0; i < 30; i++) step(1, 2047, 2047, 1);
    stream_rand(300, 1'b1);
    drain();

    // R2: reset mid-stream, filter history restarts from zero
    for (int i = 0; i < 5; i++) step(1, 1000, -500, 0);
    do_reset();
    cur_tag = "R2";
    for (int i = 0; i < 20; i++) step(1, 700, 900, 1);
    drain();

    // R7: filter off again, upper cells must stay dark
    fir_en = 1'b0;
    cur_tag = "R7";
    stream_rand(100, 1'b1);
    drain();

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule